// File: doc/BRIEF.md
# Bipolar Charge-Quantum Pulser Controller

This block is the digital sequencer of one channel of a charge-balancing current-to-frequency converter. An integrating amplifier feeds two comparators. One fires when the integrator output passes an upper threshold and the other fires when it passes a lower threshold. The controller brings both comparator levels into its clock domain. When it sees a crossing, it runs a fixed four-cycle sequence that fires a pulser of the opposite charge sign, so that exactly one charge quantum moves the integrator back toward its centre.

Each quantum also gives one count strobe with a sign bit, which a downstream counter accumulates. The sequence is short and of fixed length, and a held threshold simply retriggers it every four cycles. The integrator is therefore always being pulled back and never saturates, and the channel converts continuously with no dead time. Comparator activity that arrives while a sequence is running is not acted on. A crossing of both thresholds seen at the same moment is resolved in favour of the upper threshold.

Top module: `qpulse_ctrl`

## Requirements
- R1: While `rst_n` is low, `inj_sub`, `inj_add`, `cnt_stb` and `cnt_sign` are all 0, and this holds from the moment reset is asserted, even in the middle of a sequence and with comparators held high. After release, nothing is driven until a comparator is seen.
- R2: Each comparator passes through `SYNC_STAGES` flops. If a comparator is first sampled high at rising edge k, the matching pulser drive is high in the cycle that follows edge k+`SYNC_STAGES`+1.
- R3: An upper-threshold crossing (`cmp_pos`) gives exactly one cycle of `inj_sub` (quantum removed from the integrator), and `inj_add` stays 0 for that sequence.
- R4: A lower-threshold crossing (`cmp_neg`) gives exactly one cycle of `inj_add` (quantum added), and `inj_sub` stays 0 for that sequence.
- R5: A sequence lasts four cycles: latch polarity, drive, release with count, back to idle. `cnt_stb` is high for exactly the one cycle that follows each drive cycle. With a comparator held high, successive drives are exactly four cycles apart.
- R6: `cnt_sign` is 1 during a strobe that follows `inj_sub` and 0 during a strobe that follows `inj_add`. It is 0 whenever `cnt_stb` is 0.
- R7: If both synchronised comparators are high when the sequencer is idle, the upper threshold wins: `inj_sub` fires and `inj_add` does not.
- R8: Comparator activity that reaches the sequencer while a sequence is running starts no extra sequence.
- R9: `inj_sub` and `inj_add` are never high in the same cycle, and no drive is high in the same cycle as `cnt_stb`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset; deassert synchronously to `clk` |
| cmp_pos | input | 1 | Upper-threshold comparator level (asynchronous) |
| cmp_neg | input | 1 | Lower-threshold comparator level (asynchronous) |
| inj_sub | output | 1 | Pulser drive that removes one quantum |
| inj_add | output | 1 | Pulser drive that adds one quantum |
| cnt_stb | output | 1 | One-cycle count strobe, one per quantum |
| cnt_sign | output | 1 | Sign of the counted quantum, 1 = upper threshold |

## Verification
The bench builds the controller with `SYNC_STAGES` = 3 rather than the default 2. The measured latency from comparator to drive then depends on the parameter, and a hard-coded depth in the RTL would be exposed. A behavioural model runs beside the design, made of a delay queue per comparator and a phase counter, and every output is compared against it on every cycle. Directed runs then cover the following cases:
- a single pulse of each polarity;
- both comparators rising together;
- a threshold held high for forty cycles, which should give ten quanta;
- an opposite-polarity pulse that lands while a sequence is in flight;
- a reset asserted in the middle of a sequence.

// File: rtl/qpulse_pkg.sv
`timescale 1ns/1ps
package qpulse_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_ARM     = 2'd1,
    ST_INJECT  = 2'd2,
    ST_RELEASE = 2'd3
  } qp_state_e;

  typedef struct packed {
    logic sub;
    logic add;
    logic stb;
    logic sign;
  } qp_out_t;

  localparam int unsigned QP_CMP_W = 2;

endpackage

// File: rtl/qp_sync.sv
`timescale 1ns/1ps
module qp_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);

  localparam int unsigned LAST = STAGES - 1;

  logic [WIDTH-1:0] chain [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= '0;
          else        chain[g] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= '0;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign q_sync = chain[LAST];

endmodule

// File: rtl/qp_seq.sv
`timescale 1ns/1ps
module qp_seq
  import qpulse_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      hit_pos,
  input  logic      hit_neg,
  output qp_state_e state_nxt,
  output logic      pol_nxt
);

  qp_state_e state_q;
  logic      pol_q;
  logic      start;

  // a sequence may only start from idle; upper threshold has priority
  assign start   = (state_q == ST_IDLE) && (hit_pos || hit_neg);
  assign pol_nxt = start ? hit_pos : pol_q;

  always_comb begin
    state_nxt = state_q;
    unique case (state_q)
      ST_IDLE:    if (start) state_nxt = ST_ARM;
      ST_ARM:     state_nxt = ST_INJECT;
      ST_INJECT:  state_nxt = ST_RELEASE;
      ST_RELEASE: state_nxt = ST_IDLE;
      default:    state_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_nxt;
  end

  // polarity register, loaded only on sequence start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pol_q <= 1'b0;
    else if (start) pol_q <= hit_pos;
  end

endmodule

// File: rtl/qp_out.sv
`timescale 1ns/1ps
module qp_out
  import qpulse_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  qp_state_e state_nxt,
  input  logic      pol_nxt,
  output qp_out_t   out_q
);

  qp_out_t out_d;

  // decode the coming state so the registered drives line up with it
  always_comb begin
    out_d      = '0;
    out_d.sub  = (state_nxt == ST_INJECT)  &&  pol_nxt;
    out_d.add  = (state_nxt == ST_INJECT)  && !pol_nxt;
    out_d.stb  = (state_nxt == ST_RELEASE);
    out_d.sign = (state_nxt == ST_RELEASE) &&  pol_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= '0;
    else        out_q <= out_d;
  end

endmodule

// File: rtl/qpulse_ctrl.sv
`timescale 1ns/1ps
module qpulse_ctrl
  import qpulse_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmp_pos,
  input  logic cmp_neg,
  output logic inj_sub,
  output logic inj_add,
  output logic cnt_stb,
  output logic cnt_sign
);

  logic [QP_CMP_W-1:0] cmp_s;
  qp_state_e           state_nxt;
  logic                pol_nxt;
  qp_out_t             out_q;

  qp_sync #(
    .STAGES (SYNC_STAGES),
    .WIDTH  (QP_CMP_W)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async ({cmp_pos, cmp_neg}),
    .q_sync  (cmp_s)
  );

  qp_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .hit_pos   (cmp_s[1]),
    .hit_neg   (cmp_s[0]),
    .state_nxt (state_nxt),
    .pol_nxt   (pol_nxt)
  );

  qp_out u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .state_nxt (state_nxt),
    .pol_nxt   (pol_nxt),
    .out_q     (out_q)
  );

  assign inj_sub  = out_q.sub;
  assign inj_add  = out_q.add;
  assign cnt_stb  = out_q.stb;
  assign cnt_sign = out_q.sign;

endmodule

// File: rtl/qpulse_ctrl_chk.sv
`timescale 1ns/1ps
module qpulse_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic inj_sub,
  input logic inj_add,
  input logic cnt_stb,
  input logic cnt_sign
);

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |-> (!inj_sub && !inj_add && !cnt_stb && !cnt_sign));

  p_sub_one_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    inj_sub |=> !inj_sub);

  p_add_one_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    inj_add |=> !inj_add);

  p_drive_then_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (inj_sub || inj_add) |=> cnt_stb);

  p_count_after_drive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_stb |-> $past(inj_sub || inj_add));

  p_drive_spacing_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (inj_sub || inj_add) |-> (!$past(cnt_stb, 1) && !$past(cnt_stb, 2)));

  p_sign_pos_r6: assert property (@(posedge clk) disable iff (!rst_n)
    inj_sub |=> (cnt_stb && cnt_sign));

  p_sign_neg_r6: assert property (@(posedge clk) disable iff (!rst_n)
    inj_add |=> (cnt_stb && !cnt_sign));

  p_sign_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_stb |-> !cnt_sign);

  p_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({inj_sub, inj_add, cnt_stb}) <= 1);

endmodule

bind qpulse_ctrl qpulse_ctrl_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .inj_sub  (inj_sub),
  .inj_add  (inj_add),
  .cnt_stb  (cnt_stb),
  .cnt_sign (cnt_sign)
);

// File: tb/sim_qpulse_ctrl.sv
`timescale 1ns/1ps
module sim_qpulse_ctrl;

  localparam int SS = 3;

  logic clk;
  logic rst_n;
  logic cmp_pos;
  logic cmp_neg;
  logic inj_sub;
  logic inj_add;
  logic cnt_stb;
  logic cnt_sign;

  int checks;
  int failures;
  int cyc;
  int n_sub;
  int n_add;
  int n_stb;
  bit done;

  qpulse_ctrl #(.SYNC_STAGES(SS)) u0 (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmp_pos  (cmp_pos),
    .cmp_neg  (cmp_neg),
    .inj_sub  (inj_sub),
    .inj_add  (inj_add),
    .cnt_stb  (cnt_stb),
    .cnt_sign (cnt_sign)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit mq_p[$];
  bit mq_n[$];
  int ph;
  bit mpol;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mq_p.delete();
      mq_n.delete();
      for (int i = 0; i < SS; i++) begin
        mq_p.push_back(1'b0);
        mq_n.push_back(1'b0);
      end
      ph   = 0;
      mpol = 1'b0;
    end else begin
      bit hp;
      bit hn;
      hp = mq_p.pop_front();
      hn = mq_n.pop_front();
      mq_p.push_back(cmp_pos);
      mq_n.push_back(cmp_neg);
      if (ph == 0) begin
        if (hp || hn) begin
          mpol = hp;
          ph   = 1;
        end
      end else if (ph == 3) begin
        ph = 0;
      end else begin
        ph = ph + 1;
      end
    end
  end

  always @(posedge clk) cyc <= cyc + 1;

  // compare on every falling edge, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R3", "inj_sub",  int'(inj_sub),  int'(ph == 2 &&  mpol));
      chk("R4", "inj_add",  int'(inj_add),  int'(ph == 2 && !mpol));
      chk("R5", "cnt_stb",  int'(cnt_stb),  int'(ph == 3));
      chk("R6", "cnt_sign", int'(cnt_sign), int'(ph == 3 && mpol));
      chk("R9", "exclusive", int'(inj_sub) + int'(inj_add) + int'(cnt_stb) > 1 ? 1 : 0, 0);
      if (inj_sub) n_sub++;
      if (inj_add) n_add++;
      if (cnt_stb) n_stb++;
    end
  end

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic outs_zero(string req);
    chk(req, "all outputs low", int'({inj_sub, inj_add, cnt_stb, cnt_sign}), 0);
  endtask

  // ---------------- watchdog ----------------
  always @(posedge clk) begin
    if (cyc > 20000 && !done) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected<=20000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // ---------------- directed stimulus ----------------
  initial begin
    int s0, a0, b0, t0, g;
    checks = 0; failures = 0; cyc = 0; done = 0;
    n_sub = 0; n_add = 0; n_stb = 0;
    rst_n = 1'b0; cmp_pos = 1'b0; cmp_neg = 1'b0;
    step(3);
    outs_zero("R1");
    rst_n = 1'b1;
    step(8);
    outs_zero("R1");

    // R2 + R3: single upper pulse, latency and one quantum
    s0 = n_sub; a0 = n_add; b0 = n_stb;
    cmp_pos = 1'b1; t0 = cyc + 1;
    step();
    cmp_pos = 1'b0;
    g = 0;
    while (!inj_sub && g < 30) begin @(negedge clk); g++; end
    chk("R2", "cycle of first drive", cyc, t0 + SS + 1);
    step(12);
    chk("R3", "sub pulses", n_sub - s0, 1);
    chk("R3", "add pulses", n_add - a0, 0);
    chk("R5", "strobes", n_stb - b0, 1);

    // R4: single lower pulse
    s0 = n_sub; a0 = n_add; b0 = n_stb;
    cmp_neg = 1'b1;
    step();
    cmp_neg = 1'b0;
    step(14);
    chk("R4", "add pulses", n_add - a0, 1);
    chk("R4", "sub pulses", n_sub - s0, 0);
    chk("R5", "strobes", n_stb - b0, 1);

    // R7: both together -> upper wins
    s0 = n_sub; a0 = n_add;
    cmp_pos = 1'b1; cmp_neg = 1'b1;
    step();
    cmp_pos = 1'b0; cmp_neg = 1'b0;
    step(14);
    chk("R7", "sub pulses", n_sub - s0, 1);
    chk("R7", "add pulses", n_add - a0, 0);

    // R5: held upper threshold for 40 samples -> 10 quanta, every 4 cycles
    s0 = n_sub; b0 = n_stb;
    cmp_pos = 1'b1;
    step(40);
    cmp_pos = 1'b0;
    step(16);
    chk("R5", "strobes while held", n_stb - b0, 10);
    chk("R5", "sub pulses while held", n_sub - s0, 10);

    // R8: lower pulse landing mid-sequence is ignored
    s0 = n_sub; a0 = n_add; b0 = n_stb;
    cmp_pos = 1'b1;
    step();
    cmp_pos = 1'b0; cmp_neg = 1'b1;
    step(2);
    cmp_neg = 1'b0;
    step(16);
    chk("R8", "add pulses", n_add - a0, 0);
    chk("R8", "strobes", n_stb - b0, 1);
    chk("R8", "sub pulses", n_sub - s0, 1);

    // R1: reset in the middle of a held sequence
    cmp_neg = 1'b1;
    step(SS + 2);
    rst_n = 1'b0;
    #1;
    outs_zero("R1");
    for (int k = 0; k < 4; k++) begin
      step();
      outs_zero("R1");
    end
    cmp_neg = 1'b0;
    rst_n = 1'b1;
    b0 = n_stb;
    step(12);
    chk("R1", "strobes after release with no comparator", n_stb - b0, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule